// File: doc/BRIEF.md
# Half-Bit Sampled IR Frame Decoder

This block turns a demodulated infrared level into a decoded remote-control frame. A strobe from a local timer marks each half-bit period, and on each strobe the block samples the IR level once. It then moves one step through a single numbered state sequence. The low states walk a fixed lead-in pattern: three or more high samples, then low, high, low. Each sample picks one of two successor states, and any unexpected sample drops the sequence back to idle. Past the lead-in, every data bit takes two half-bit samples, and the two samples must differ (Manchester coding). The bits fill a one-bit toggle field, then the address field and then the command field, most significant bit first.

The fields collect in shadow storage. Only a complete frame copies them to the outputs and raises a frame-valid flag, which the consumer clears. For diagnostics, the block keeps the deepest state index reached since the last clear. It also tracks a push-button level: a side branch of the state table can only be reached by a run of four or more low samples from idle. That branch sets the button flag, and the next strobe taken in idle clears it.

Top module: `irm_frame_rx`

## Requirements
- R1: After a synchronous reset, frame_valid_o, toggle_o, address_o, command_o, max_state_o and button_o are all 0, and the sequence is at state 0 (idle).
- R2: Without tick_i the state, the fields and max_state_o do not change, whatever ir_i does.
- R3: Lead-in, with each state giving its next state on a 0 / 1 sample: 0: 7/1, 1: 0/2, 2: 0/3, 3: 4/3, 4: 0/5, 5: 11/0, 6: 0/0, 7: 8/0, 8: 9/0, 9: 10/0, 10: 10/0. So three or more 1s followed by 0,1,0 reach state 11, and any other sample returns the sequence to state 0.
- R4: From state 11, each data bit takes two strobes. The first sample is stored. On the second strobe a sample of 0 writes bit value 1 and a sample of 1 writes 0, so halves (1,0) carry a 1 and halves (0,1) carry a 0. Bits arrive in this order: toggle, then address MSB to LSB, then command MSB to LSB. The last half-bit leaves the sequence in state 11+2*(1+ADDR_W+CMD_W), which is 35 by default.
- R5: If both halves of a data bit are equal, the second strobe returns the sequence to state 0. frame_valid_o does not rise.
- R6: The strobe taken in the last state returns the sequence to 0 and sets frame_valid_o. clr_valid_i clears the flag. If the flag is set and cleared in the same cycle, it ends up set.
- R7: toggle_o, address_o and command_o change only when a complete frame finishes. Partial or aborted frames leave them unchanged.
- R8: max_state_o holds the highest state index entered since reset or since the last clr_max_i, and clr_max_i sets it to 0.
- R9: A strobe taken in state 10 sets button_o, and a strobe taken in state 0 clears it. No other strobe changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Half-bit sample strobe, one cycle wide |
| ir_i | input | 1 | Demodulated IR level |
| clr_valid_i | input | 1 | Consumer acknowledge; clears frame_valid_o |
| clr_max_i | input | 1 | Clears the deepest-state record |
| frame_valid_o | output | 1 | A complete frame has been received |
| toggle_o | output | 1 | Toggle field of the last complete frame |
| address_o | output | ADDR_W | Address field of the last complete frame |
| command_o | output | CMD_W | Command field of the last complete frame |
| max_state_o | output | ST_W | Deepest state index reached |
| button_o | output | 1 | Push-button level tracked by the idle branch |

## Verification
The bench builds the block with its default widths: a 5-bit address and a 6-bit command, so a complete frame ends in state 35. With these widths max_state_o becomes a window onto the state sequence. After clearing it and applying a few strobes, its value shows which lead-in branch was taken and whether the sequence went back to idle. The default widths also bring both field boundaries within reach, together with the deepest data state and an abort partway through the address field.

// File: rtl/irm_pkg.sv
package irm_pkg;

    // Named lead-in states
    localparam int unsigned S_IDLE     = 0;
    localparam int unsigned S_LEAD1    = 1;
    localparam int unsigned S_LEAD2    = 2;
    localparam int unsigned S_LEADRUN  = 3;
    localparam int unsigned S_GAP      = 4;
    localparam int unsigned S_SYNC     = 5;
    localparam int unsigned S_DEAD     = 6;
    localparam int unsigned S_LOW1     = 7;
    localparam int unsigned S_LOW2     = 8;
    localparam int unsigned S_LOW3     = 9;
    localparam int unsigned S_BTNHOLD  = 10;
    localparam int unsigned S_DATA0    = 11;

    typedef enum logic [1:0] {
        FLD_NONE   = 2'd0,
        FLD_TOGGLE = 2'd1,
        FLD_ADDR   = 2'd2,
        FLD_CMD    = 2'd3
    } field_e;

    // Successor pair of one lead-in state
    typedef struct packed {
        logic [7:0] on_zero;
        logic [7:0] on_one;
    } succ_t;

    function automatic succ_t lead_succ(input int unsigned st);
        succ_t r;
        case (st)
            S_IDLE:    r = '{8'(S_LOW1),    8'(S_LEAD1)};
            S_LEAD1:   r = '{8'(S_IDLE),    8'(S_LEAD2)};
            S_LEAD2:   r = '{8'(S_IDLE),    8'(S_LEADRUN)};
            S_LEADRUN: r = '{8'(S_GAP),     8'(S_LEADRUN)};
            S_GAP:     r = '{8'(S_IDLE),    8'(S_SYNC)};
            S_SYNC:    r = '{8'(S_DATA0),   8'(S_IDLE)};
            S_LOW1:    r = '{8'(S_LOW2),    8'(S_IDLE)};
            S_LOW2:    r = '{8'(S_LOW3),    8'(S_IDLE)};
            S_LOW3:    r = '{8'(S_BTNHOLD), 8'(S_IDLE)};
            S_BTNHOLD: r = '{8'(S_BTNHOLD), 8'(S_IDLE)};
            default:   r = '{8'(S_IDLE),    8'(S_IDLE)};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irm_lead_fsm.sv
module irm_lead_fsm
    import irm_pkg::*;
#(
    parameter int ST_W = 6
) (
    input  logic [ST_W-1:0] cur_i,
    input  logic            sample_i,
    output logic [ST_W-1:0] nxt_o,
    output logic            btn_set_o,
    output logic            btn_clr_o
);
    succ_t pair;

    always_comb begin
        pair      = lead_succ(int'(cur_i));
        nxt_o     = sample_i ? ST_W'(pair.on_one) : ST_W'(pair.on_zero);
        btn_set_o = (cur_i == ST_W'(S_BTNHOLD));
        btn_clr_o = (cur_i == ST_W'(S_IDLE));
    end
endmodule

// File: rtl/irm_bit_slicer.sv
module irm_bit_slicer
    import irm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CMD_W  = 6,
    parameter int ST_W   = 6,
    parameter int IDX_W  = 3
) (
    input  logic [ST_W-1:0]  cur_i,
    input  logic             sample_i,
    input  logic             half_i,
    output logic [ST_W-1:0]  nxt_o,
    output logic             first_o,
    output logic             abort_o,
    output field_e           fld_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             val_o
);
    logic [ST_W-1:0] off;
    int              k;

    always_comb begin
        off     = cur_i - ST_W'(S_DATA0);
        k       = int'(off >> 1);
        first_o = ~off[0];
        abort_o = 1'b0;
        fld_o   = FLD_NONE;
        idx_o   = '0;
        val_o   = ~sample_i;
        nxt_o   = cur_i + ST_W'(1);
        if (!first_o) begin
            if (sample_i == half_i) begin
                abort_o = 1'b1;
                nxt_o   = ST_W'(S_IDLE);
            end else if (k == 0) begin
                fld_o = FLD_TOGGLE;
            end else if (k <= ADDR_W) begin
                fld_o = FLD_ADDR;
                idx_o = IDX_W'(ADDR_W - k);
            end else begin
                fld_o = FLD_CMD;
                idx_o = IDX_W'(ADDR_W + CMD_W - k);
            end
        end
    end
endmodule

// File: rtl/irm_field_regs.sv
module irm_field_regs
    import irm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CMD_W  = 6,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  field_e            fld_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              val_i,
    input  logic              commit_i,
    output logic              toggle_o,
    output logic [ADDR_W-1:0] address_o,
    output logic [CMD_W-1:0]  command_o
);
    logic              tog_sh;
    logic [ADDR_W-1:0] addr_sh;
    logic [CMD_W-1:0]  cmd_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_sh    <= 1'b0;
            addr_sh   <= '0;
            cmd_sh    <= '0;
            toggle_o  <= 1'b0;
            address_o <= '0;
            command_o <= '0;
        end else begin
            if (wr_i) begin
                if (fld_i == FLD_TOGGLE) tog_sh <= val_i;
                for (int i = 0; i < ADDR_W; i++)
                    if (fld_i == FLD_ADDR && int'(idx_i) == i) addr_sh[i] <= val_i;
                for (int i = 0; i < CMD_W; i++)
                    if (fld_i == FLD_CMD && int'(idx_i) == i) cmd_sh[i] <= val_i;
            end
            if (commit_i) begin
                toggle_o  <= tog_sh;
                address_o <= addr_sh;
                command_o <= cmd_sh;
            end
        end
    end

    // R7: outputs move only on a frame commit
    a_r7_fields_held: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> ($stable(address_o) && $stable(command_o) && $stable(toggle_o)));
endmodule

// File: rtl/irm_frame_rx.sv
module irm_frame_rx
    import irm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CMD_W  = 6,
    localparam int NBITS   = 1 + ADDR_W + CMD_W,
    localparam int LAST_ST = S_DATA0 + 2 * NBITS,
    localparam int ST_W    = $clog2(LAST_ST + 1),
    localparam int MAXW    = (ADDR_W > CMD_W) ? ADDR_W : CMD_W,
    localparam int IDX_W   = $clog2(MAXW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              ir_i,
    input  logic              clr_valid_i,
    input  logic              clr_max_i,
    output logic              frame_valid_o,
    output logic              toggle_o,
    output logic [ADDR_W-1:0] address_o,
    output logic [CMD_W-1:0]  command_o,
    output logic [ST_W-1:0]   max_state_o,
    output logic              button_o
);
    logic [ST_W-1:0]  state_q, nxt;
    logic [ST_W-1:0]  lead_nxt, data_nxt;
    logic             half_q;
    logic             btn_set, btn_clr;
    logic             in_lead, in_data, at_last;
    logic             first_half, abort;
    field_e           fld;
    logic [IDX_W-1:0] idx;
    logic             bit_val;
    logic             wr, commit;

    irm_lead_fsm #(.ST_W(ST_W)) lead_i (
        .cur_i(state_q), .sample_i(ir_i), .nxt_o(lead_nxt),
        .btn_set_o(btn_set), .btn_clr_o(btn_clr)
    );

    irm_bit_slicer #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .ST_W(ST_W), .IDX_W(IDX_W)) slice_i (
        .cur_i(state_q), .sample_i(ir_i), .half_i(half_q), .nxt_o(data_nxt),
        .first_o(first_half), .abort_o(abort), .fld_o(fld), .idx_o(idx), .val_o(bit_val)
    );

    always_comb begin
        in_lead = (state_q < ST_W'(S_DATA0));
        at_last = (state_q == ST_W'(LAST_ST));
        in_data = !in_lead && !at_last;
        if (in_lead)      nxt = lead_nxt;
        else if (at_last) nxt = ST_W'(S_IDLE);
        else              nxt = data_nxt;
        wr     = tick_i && in_data && !first_half && !abort;
        commit = tick_i && at_last;
    end

    irm_field_regs #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .IDX_W(IDX_W)) regs_i (
        .clk(clk), .rst(rst), .wr_i(wr), .fld_i(fld), .idx_i(idx), .val_i(bit_val),
        .commit_i(commit), .toggle_o(toggle_o), .address_o(address_o), .command_o(command_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_W'(S_IDLE);
            half_q        <= 1'b0;
            max_state_o   <= '0;
            frame_valid_o <= 1'b0;
            button_o      <= 1'b0;
        end else begin
            if (tick_i) begin
                state_q <= nxt;
                if (in_data && first_half) half_q <= ir_i;
                if (in_lead && btn_set) button_o <= 1'b1;
                if (in_lead && btn_clr) button_o <= 1'b0;
            end
            if (clr_max_i)                         max_state_o <= '0;
            else if (tick_i && nxt > max_state_o)  max_state_o <= nxt;
            if (commit)           frame_valid_o <= 1'b1;
            else if (clr_valid_i) frame_valid_o <= 1'b0;
        end
    end

    // R2: no strobe, no movement
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(state_q));
    // R4: state index never passes the final data state
    a_r4_state_range: assert property (@(posedge clk) disable iff (rst)
        state_q <= ST_W'(LAST_ST));
    // R6: valid only rises after a strobe in the last state
    a_r6_valid_source: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid_o) |-> ($past(tick_i) && $past(state_q) == ST_W'(LAST_ST)));
    // R8: clear empties the record
    a_r8_max_clear: assert property (@(posedge clk) disable iff (rst)
        clr_max_i |=> max_state_o == '0);
    // R9: button only moves on a strobe
    a_r9_button_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(button_o) |-> $past(tick_i));
    // R5: an abort never raises valid
    a_r5_abort_no_valid: assert property (@(posedge clk) disable iff (rst)
        (tick_i && in_data && abort && !frame_valid_o) |=> !frame_valid_o);
endmodule

// File: tb/irm_frame_rx_tb.sv
module irm_frame_rx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, ir = 1'b0, clr_valid = 1'b0, clr_max = 1'b0;
    logic       frame_valid, toggle, button;
    logic [4:0] address;
    logic [5:0] command;
    logic [5:0] max_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic       t;
        logic [4:0] a;
        logic [5:0] c;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irm_frame_rx dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .ir_i(ir),
        .clr_valid_i(clr_valid), .clr_max_i(clr_max),
        .frame_valid_o(frame_valid), .toggle_o(toggle), .address_o(address),
        .command_o(command), .max_state_o(max_state), .button_o(button)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half(input logic b);
        @(negedge clk); tick = 1'b1; ir = b;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic lead_in(input int ones);
        for (int i = 0; i < ones; i++) half(1'b1);
        half(1'b0); half(1'b1); half(1'b0);
    endtask

    task automatic data_bit(input logic b);
        half(b); half(~b);
    endtask

    task automatic pulse_clr_max();
        @(negedge clk); clr_max = 1'b1;
        @(negedge clk); clr_max = 1'b0;
    endtask

    task automatic pulse_clr_valid();
        @(negedge clk); clr_valid = 1'b1;
        @(negedge clk); clr_valid = 1'b0;
    endtask

    // Driver: pushes the expected frame, then plays it
    task automatic send_frame(input logic t, input logic [4:0] a, input logic [5:0] c,
                              input int ones, input logic clr_same);
        logic [11:0] v;
        exp_q.push_back('{t, a, c});
        v = {t, a, c};
        lead_in(ones);
        for (int i = 11; i >= 0; i--) data_bit(v[i]);
        @(negedge clk); tick = 1'b1; clr_valid = clr_same;
        @(negedge clk); tick = 1'b0; clr_valid = 1'b0;
    endtask

    // Monitor: pops on every rising frame_valid
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst && frame_valid && !prev_valid) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected frame", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R4 toggle", toggle, e.t);
                check("R4 address", address, e.a);
                check("R4 command", command, e.c);
            end
        end
        prev_valid <= frame_valid;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid", frame_valid, 0);
        check("R1 toggle", toggle, 0);
        check("R1 address", address, 0);
        check("R1 command", command, 0);
        check("R1 max", max_state, 0);
        check("R1 button", button, 0);

        // R2 level changes without strobes
        for (int i = 0; i < 6; i++) begin @(negedge clk); ir = i[0]; end
        @(negedge clk);
        check("R2 max untouched", max_state, 0);

        // Frame A
        send_frame(1'b1, 5'h15, 6'h2A, 3, 1'b0);
        check("R6 valid set", frame_valid, 1);
        check("R8 deepest", max_state, 35);
        repeat (3) @(negedge clk);
        check("R6 valid held", frame_valid, 1);
        pulse_clr_valid();
        check("R6 valid cleared", frame_valid, 0);
        pulse_clr_max();
        check("R8 cleared", max_state, 0);

        // R5 abort mid-address, R7 outputs held
        lead_in(3);
        data_bit(1'b0); data_bit(1'b1);
        check("R7 addr held mid-frame", address, 5'h15);
        data_bit(1'b1);
        half(1'b1); half(1'b1);
        check("R5 abort depth", max_state, 18);
        check("R5 no valid", frame_valid, 0);
        check("R7 addr after abort", address, 5'h15);
        check("R7 cmd after abort", command, 6'h2A);
        check("R7 toggle after abort", toggle, 1);
        pulse_clr_max();
        half(1'b1);
        check("R5 back at idle", max_state, 1);
        half(1'b0);

        // R3 deviation from state 2
        pulse_clr_max();
        half(1'b1); half(1'b1); half(1'b0);
        check("R3 reached 2", max_state, 2);
        pulse_clr_max();
        half(1'b1);
        check("R3 state2 on 0 to idle", max_state, 1);
        half(1'b0);
        // R3 deviation from state 5
        pulse_clr_max();
        half(1'b1); half(1'b1); half(1'b1); half(1'b0); half(1'b1); half(1'b1);
        check("R3 reached 5", max_state, 5);
        pulse_clr_max();
        half(1'b1);
        check("R3 state5 on 1 to idle", max_state, 1);
        half(1'b0);

        // Frame B: long lead-in run, set and clear together
        send_frame(1'b0, 5'h07, 6'h0C, 5, 1'b1);
        check("R6 set wins over clear", frame_valid, 1);
        pulse_clr_valid();

        // R9 button branch
        pulse_clr_max();
        half(1'b0); half(1'b0); half(1'b0); half(1'b0);
        check("R9 reached 10", max_state, 10);
        check("R9 not yet set", button, 0);
        half(1'b0);
        check("R9 set in state 10", button, 1);
        half(1'b1);
        check("R9 held on exit", button, 1);
        half(1'b0);
        check("R9 cleared in idle", button, 0);
        half(1'b1);
        pulse_clr_max();
        half(1'b1);
        check("R3 state7 on 1 to idle", max_state, 1);
        half(1'b0);

        // Frame C: zero address, all-ones command
        send_frame(1'b0, 5'h00, 6'h3F, 4, 1'b0);
        check("R6 valid frame C", frame_valid, 1);
        pulse_clr_valid();
        repeat (2) @(negedge clk);
        check("R4 all frames seen", exp_q.size(), 0);
        finish_run();
    end
endmodule